// File: doc/BRIEF.md
# Dual-Class Vectored Interrupt Controller

This block gathers 64 level-driven interrupt sources and presents them to a processor as two request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Each source carries an enable bit, a class bit (normal or fast) and a 4-bit priority. Fast-class requests are raised without any gating. Normal-class requests pass a priority threshold before they reach the processor.

Software reaches the controller over a plain 32-bit word-indexed register port with address, write enable, read enable, write data and read data. Through it, software:

- sets the enable mask, either whole-word or one source at a time by number;
- chooses the class of each source;
- programs the packed priority words;
- forces pending bits;
- reads raw and per-class pending views.

Two vector words report the winning normal or fast source. Reading one of them acknowledges that source by clearing its pending bit.

The winner among pending normal sources is chosen by a separate selector instance. That selector also supplies the highest pending priority used by the threshold gate.

Top module: `dcvic_top`

## Requirements
- R1: `fiq_o` is high exactly when at least one source is pending, enabled and has its class bit set to 1 (fast).
- R2: `irq_o` is high when some pending, enabled source with class bit 0 (normal) has a priority strictly greater than the 5-bit mask. When the mask is 0x1F, any such source raises `irq_o` whatever its priority.
- R3: Word indices: 0 control (32 bits kept), 1 mask (bits [4:0] kept), 4/5 enable high/low, 6/7 class high/low. All of these read back what was written. High words hold sources 63..32 and low words hold sources 31..0, with source n at bit n mod 32.
- R4: A write to word 2 sets the enable bit numbered `wdata_i[5:0]`. A write to word 3 clears that bit. Words 2 and 3 read as zero.
- R5: Priority word 8+k (k = 0..7) holds the priorities of sources 8*(7-k) to 8*(7-k)+7, one 4-bit field each. Source 8*(7-k)+j sits at bits [4j+3:4j].
- R6: A write to word 20 (high) or word 21 (low) overwrites that half of the pending vector. Words 20 and 21 read as zero.
- R7: After reset the following are all zero: pending, enable, class, control and every priority. The mask reads 0x1F, and both request lines are low.
- R8: A read of word 16 returns `{source number in bits [21:16], priority in bits [3:0]}` for the pending, enabled, normal source with the highest priority. On a tie, the highest-numbered source wins. With no such source the word reads 0xFFFFFFFF. A read with `re_i` high clears the reported source's pending bit at that clock edge.
- R9: A read of word 17 returns the lowest-numbered pending, enabled, fast source, or 0xFFFFFFFF if there is none. It clears that source's pending bit at the clock edge.
- R10: A rising source level sets its pending bit at the next clock edge, and a falling level clears it. If a vector read acknowledges a source in the same cycle its level rises, the bit ends up clear.
- R11: Writes to words 16 to 19 and 22 to 25, and to unmapped indices 26 to 63, change nothing. Unmapped indices read as zero.
- R12: Words 18/19 read the raw pending vector (high/low). Words 22/23 read pending & enable & ~class, and words 24/25 read pending & enable & class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Source levels |
| addr_i | input | 6 | Register word index |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; acknowledges on vector words, ignored while `we_i` is high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 64 sources, 4-bit priorities and 32-bit words. These are the only values under which the word map is complete, so the bench exercises both halves of every split register and all eight priority words.

With those values, the bench can check the following directly at the ports:
- a priority tie between source 1 and source 63, which lie in different words;
- threshold comparisons one step either side of a source's priority;
- the open mask value;
- an acknowledge that collides with a rising source level on the same edge.

// File: rtl/dcvic_pkg.sv
package dcvic_pkg;
  localparam logic [5:0] W_CTRL     = 6'd0;
  localparam logic [5:0] W_MASK     = 6'd1;
  localparam logic [5:0] W_ENNUM    = 6'd2;
  localparam logic [5:0] W_DISNUM   = 6'd3;
  localparam logic [5:0] W_EN_HI    = 6'd4;
  localparam logic [5:0] W_EN_LO    = 6'd5;
  localparam logic [5:0] W_TYP_HI   = 6'd6;
  localparam logic [5:0] W_TYP_LO   = 6'd7;
  localparam logic [5:0] W_PRIO_TOP = 6'd8;
  localparam logic [5:0] W_PRIO_BOT = 6'd15;
  localparam logic [5:0] W_NVEC     = 6'd16;
  localparam logic [5:0] W_FVEC     = 6'd17;
  localparam logic [5:0] W_RAW_HI   = 6'd18;
  localparam logic [5:0] W_RAW_LO   = 6'd19;
  localparam logic [5:0] W_FRC_HI   = 6'd20;
  localparam logic [5:0] W_FRC_LO   = 6'd21;
  localparam logic [5:0] W_NPND_HI  = 6'd22;
  localparam logic [5:0] W_NPND_LO  = 6'd23;
  localparam logic [5:0] W_FPND_HI  = 6'd24;
  localparam logic [5:0] W_FPND_LO  = 6'd25;
endpackage

// File: rtl/dcvic_best.sv
// Highest priority among requests; ties go to the highest index.
module dcvic_best #(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PRIO_W-1:0]       prio_o
);
  logic              f;
  logic [IDX_W-1:0]  ix;
  logic [PRIO_W-1:0] pr;

  always_comb begin
    f  = 1'b0;
    ix = '0;
    pr = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!f || prio_i[i*PRIO_W +: PRIO_W] >= pr)) begin
        f  = 1'b1;
        ix = IDX_W'(i);
        pr = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign found_o = f;
  assign idx_o   = ix;
  assign prio_o  = pr;

  // R8: a reported winner must be requesting
  always_comb begin
    if (found_o) a_r8_winner_req: assert (req_i[idx_o]);
  end
endmodule

// File: rtl/dcvic_lowest.sv
// Lowest-numbered request.
module dcvic_lowest #(
  parameter int N_SRC  = 64,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             f;
  logic [IDX_W-1:0] ix;

  always_comb begin
    f  = 1'b0;
    ix = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        f  = 1'b1;
        ix = IDX_W'(i);
      end
    end
  end

  assign found_o = f;
  assign idx_o   = ix;

  // R9: winner requests and nothing below it does
  always_comb begin
    if (found_o) begin
      a_r9_lowest_req: assert (req_i[idx_o]);
      a_r9_none_below: assert ((req_i & ((N_SRC'(1) << idx_o) - N_SRC'(1))) == '0);
    end
  end
endmodule

// File: rtl/dcvic_pend.sv
// Pending vector: level edges, acknowledge, half-word force.
module dcvic_pend #(
  parameter int N_SRC  = 64,
  parameter int DW     = 32,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int HALF  = N_SRC / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             ack_vld_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  input  logic             frc_hi_we_i,
  input  logic             frc_lo_we_i,
  input  logic [DW-1:0]    frc_data_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] src_q, pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    pend_d = pend_d | (src_i & ~src_q);
    pend_d = pend_d & ~(~src_i & src_q);
    if (ack_vld_i) pend_d[ack_idx_i] = 1'b0;  // ack beats a same-cycle rise
    if (frc_lo_we_i) pend_d[HALF-1:0] = frc_data_i[HALF-1:0];
    if (frc_hi_we_i) pend_d[N_SRC-1:HALF] = frc_data_i[HALF-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  a_r10_ack_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld_i && !frc_lo_we_i && !frc_hi_we_i) |=> !pend_q[$past(ack_idx_i)]);

  a_r6_force_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_lo_we_i |=> pend_q[HALF-1:0] == $past(frc_data_i[HALF-1:0]));

  a_r6_force_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_hi_we_i |=> pend_q[N_SRC-1:HALF] == $past(frc_data_i[HALF-1:0]));
endmodule

// File: rtl/dcvic_top.sv
module dcvic_top
  import dcvic_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int PRIO_W = 4,
  parameter int DW     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [5:0]       addr_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int IDX_W   = $clog2(N_SRC);
  localparam int MASK_W  = PRIO_W + 1;
  localparam int HALF    = N_SRC / 2;
  localparam int N_PWORD = (N_SRC * PRIO_W) / DW;
  localparam int GRP_W   = $clog2(N_PWORD);
  localparam logic [MASK_W-1:0] MASK_OPEN = '1;
  localparam logic [DW-1:0]     NO_VEC    = '1;

  logic [N_SRC-1:0]        en_q, typ_q, pend;
  logic [N_SRC-1:0]        nrm_req, fst_req;
  logic [DW-1:0]           ctrl_q;
  logic [MASK_W-1:0]       mask_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic                    n_found, f_found;
  logic [IDX_W-1:0]        n_idx, f_idx;
  logic [PRIO_W-1:0]       n_prio;
  logic                    rd, n_ack, f_ack;
  logic [GRP_W-1:0]        grp;

  assign rd    = re_i & ~we_i;
  assign n_ack = rd && addr_i == W_NVEC && n_found;
  assign f_ack = rd && addr_i == W_FVEC && f_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= MASK_OPEN;
      en_q   <= '0;
      typ_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        W_CTRL:   ctrl_q <= wdata_i;
        W_MASK:   mask_q <= wdata_i[MASK_W-1:0];
        W_ENNUM:  en_q[wdata_i[IDX_W-1:0]] <= 1'b1;
        W_DISNUM: en_q[wdata_i[IDX_W-1:0]] <= 1'b0;
        W_EN_HI:  en_q[N_SRC-1:HALF] <= wdata_i[HALF-1:0];
        W_EN_LO:  en_q[HALF-1:0] <= wdata_i[HALF-1:0];
        W_TYP_HI: typ_q[N_SRC-1:HALF] <= wdata_i[HALF-1:0];
        W_TYP_LO: typ_q[HALF-1:0] <= wdata_i[HALF-1:0];
        default: ;
      endcase
    end
  end

  // Priority word W_PRIO_BOT - g holds source group g
  for (genvar g = 0; g < N_PWORD; g++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[g*DW +: DW] <= '0;
      else if (we_i && addr_i == W_PRIO_BOT - 6'(g)) prio_q[g*DW +: DW] <= wdata_i;
    end
  end

  dcvic_pend #(.N_SRC(N_SRC), .DW(DW)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .ack_vld_i   (n_ack | f_ack),
    .ack_idx_i   (n_ack ? n_idx : f_idx),
    .frc_hi_we_i (we_i && addr_i == W_FRC_HI),
    .frc_lo_we_i (we_i && addr_i == W_FRC_LO),
    .frc_data_i  (wdata_i),
    .pend_o      (pend)
  );

  assign nrm_req = pend & en_q & ~typ_q;
  assign fst_req = pend & en_q & typ_q;

  dcvic_best #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_best (
    .req_i   (nrm_req),
    .prio_i  (prio_q),
    .found_o (n_found),
    .idx_o   (n_idx),
    .prio_o  (n_prio)
  );

  dcvic_lowest #(.N_SRC(N_SRC)) u_low (
    .req_i   (fst_req),
    .found_o (f_found),
    .idx_o   (f_idx)
  );

  assign fiq_o = |fst_req;
  assign irq_o = n_found && (mask_q == MASK_OPEN || {1'b0, n_prio} > mask_q);

  assign grp = GRP_W'(W_PRIO_BOT - addr_i);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      W_CTRL:    rdata_o = ctrl_q;
      W_MASK:    rdata_o = DW'(mask_q);
      W_EN_HI:   rdata_o = en_q[N_SRC-1:HALF];
      W_EN_LO:   rdata_o = en_q[HALF-1:0];
      W_TYP_HI:  rdata_o = typ_q[N_SRC-1:HALF];
      W_TYP_LO:  rdata_o = typ_q[HALF-1:0];
      W_NVEC:    rdata_o = n_found ? (DW'(n_idx) << 16) | DW'(n_prio) : NO_VEC;
      W_FVEC:    rdata_o = f_found ? DW'(f_idx) : NO_VEC;
      W_RAW_HI:  rdata_o = pend[N_SRC-1:HALF];
      W_RAW_LO:  rdata_o = pend[HALF-1:0];
      W_NPND_HI: rdata_o = nrm_req[N_SRC-1:HALF];
      W_NPND_LO: rdata_o = nrm_req[HALF-1:0];
      W_FPND_HI: rdata_o = fst_req[N_SRC-1:HALF];
      W_FPND_LO: rdata_o = fst_req[HALF-1:0];
      default:
        if (addr_i >= W_PRIO_TOP && addr_i <= W_PRIO_BOT) rdata_o = prio_q[grp*DW +: DW];
    endcase
  end

  a_r4_num_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == W_ENNUM) |=> en_q[$past(wdata_i[IDX_W-1:0])]);

  a_r4_num_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == W_DISNUM) |=> !en_q[$past(wdata_i[IDX_W-1:0])]);

  a_r3_mask_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == W_MASK) |=> mask_q == $past(wdata_i[MASK_W-1:0]));

  a_r1_fiq_has_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> |(pend & typ_q));

  a_r2_irq_has_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(pend & en_q & ~typ_q));
endmodule

// File: tb/sim_dcvic_top.sv
`timescale 1ns/1ps
module sim_dcvic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dcvic_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    src = '0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(6'd1, d);  chk("R7 mask", d, 32'h1f);
    rd(6'd0, d);  chk("R7 ctrl", d, 0);
    rd(6'd5, d);  chk("R7 enable lo", d, 0);
    rd(6'd6, d);  chk("R7 class hi", d, 0);
    rd(6'd12, d); chk("R7 prio", d, 0);
    rd(6'd19, d); chk("R7 raw lo", d, 0);
    chk("R7 irq", 32'(irq), 0);
    chk("R7 fiq", 32'(fiq), 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(6'd0, 32'ha5a5_0f0f); rd(6'd0, d); chk("R3 ctrl", d, 32'ha5a5_0f0f);
    wr(6'd1, 32'hff);        rd(6'd1, d); chk("R3 mask 5 bits", d, 32'h1f);
    wr(6'd1, 32'h26);        rd(6'd1, d); chk("R3 mask", d, 32'h06);
    wr(6'd4, 32'h1234_5678); rd(6'd4, d); chk("R3 enable hi", d, 32'h1234_5678);
    rd(6'd5, d); chk("R3 enable lo untouched", d, 0);
    wr(6'd7, 32'hdead_beef); rd(6'd7, d); chk("R3 class lo", d, 32'hdead_beef);
  endtask

  task automatic t_num();
    logic [31:0] d;
    do_reset();
    wr(6'd2, 32'hc5);  rd(6'd5, d); chk("R4 enable num 5", d, 32'h20);
    wr(6'd2, 32'h22);  rd(6'd4, d); chk("R4 enable num 34", d, 32'h4);
    wr(6'd3, 32'h05);  rd(6'd5, d); chk("R4 disable num 5", d, 0);
    rd(6'd4, d); chk("R4 hi kept", d, 32'h4);
    rd(6'd2, d); chk("R4 enable word reads 0", d, 0);
    rd(6'd3, d); chk("R4 disable word reads 0", d, 0);
  endtask

  task automatic t_nvec();
    logic [31:0] d;
    do_reset();
    wr(6'd4, 32'hffff_ffff); wr(6'd5, 32'hffff_ffff);
    wr(6'd15, 32'h0000_0030);  // src1 prio 3
    wr(6'd8,  32'h3000_0000);  // src63 prio 3
    wr(6'd12, 32'h0000_0500);  // src26 prio 5
    rd(6'd8, d); chk("R5 prio word 8", d, 32'h3000_0000);
    wr(6'd21, 32'h0400_0002); wr(6'd20, 32'h8000_0000);
    rd(6'd16, d); chk("R8 highest prio (R5 packing)", d, 32'h001a_0005);
    rd(6'd19, d); chk("R8 ack clears src26", d, 32'h2);
    rd(6'd16, d); chk("R8 tie highest index", d, 32'h003f_0003);
    rd(6'd16, d); chk("R8 last", d, 32'h0001_0003);
    rd(6'd16, d); chk("R8 none", d, 32'hffff_ffff);
    chk("R2 irq after drain", 32'(irq), 0);
  endtask

  task automatic t_gate();
    do_reset();
    wr(6'd5, 32'hffff_ffff);
    wr(6'd15, 32'h0006_0000);  // src4 prio 6
    wr(6'd21, 32'h10);
    chk("R2 open mask", 32'(irq), 1);
    wr(6'd1, 32'h06); chk("R2 equal not above", 32'(irq), 0);
    wr(6'd1, 32'h05); chk("R2 above", 32'(irq), 1);
    chk("R1 no fast", 32'(fiq), 0);
    wr(6'd7, 32'h10);
    chk("R1 fast", 32'(fiq), 1);
    chk("R2 fast not irq", 32'(irq), 0);
    wr(6'd3, 32'h04);
    chk("R1 disabled", 32'(fiq), 0);
  endtask

  task automatic t_fvec();
    logic [31:0] d;
    do_reset();
    wr(6'd4, 32'hffff_ffff); wr(6'd5, 32'hffff_ffff);
    wr(6'd6, 32'hffff_ffff); wr(6'd7, 32'hffff_ffff);
    wr(6'd21, 32'h8000_0008); wr(6'd20, 32'h1);
    rd(6'd17, d); chk("R9 lowest", d, 3);
    rd(6'd17, d); chk("R9 next", d, 31);
    rd(6'd17, d); chk("R9 high half", d, 32);
    chk("R1 fiq drained", 32'(fiq), 0);
    rd(6'd17, d); chk("R9 none", d, 32'hffff_ffff);
  endtask

  task automatic t_views();
    logic [31:0] d;
    do_reset();
    wr(6'd21, 32'hf); wr(6'd20, 32'h3);
    wr(6'd5, 32'h5);  wr(6'd4, 32'h3);
    wr(6'd7, 32'h4);  wr(6'd6, 32'h2);
    rd(6'd19, d); chk("R12 raw lo", d, 32'hf);
    rd(6'd18, d); chk("R12 raw hi", d, 32'h3);
    rd(6'd23, d); chk("R12 normal lo", d, 32'h1);
    rd(6'd22, d); chk("R12 normal hi", d, 32'h1);
    rd(6'd25, d); chk("R12 fast lo", d, 32'h4);
    rd(6'd24, d); chk("R12 fast hi", d, 32'h2);
    wr(6'd21, 32'h100);
    rd(6'd19, d); chk("R6 force lo overwrites", d, 32'h100);
    rd(6'd18, d); chk("R6 hi kept", d, 32'h3);
    rd(6'd21, d); chk("R6 force reads 0", d, 0);
  endtask

  task automatic t_src();
    logic [31:0] d;
    do_reset();
    @(negedge clk); src[7] = 1'b1;
    rd(6'd19, d); chk("R10 rise sets", d, 32'h80);
    @(negedge clk); src[7] = 1'b0;
    rd(6'd19, d); chk("R10 fall clears", d, 0);
    wr(6'd2, 32'd9);
    wr(6'd21, 32'h200);
    @(negedge clk); addr = 6'd16; re = 1'b1; src[9] = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
    chk("R10 vector during race", d, 32'h0009_0000);
    rd(6'd19, d); chk("R10 ack beats rise", d, 0);
    @(negedge clk); src[9] = 1'b0;
    @(negedge clk); src[9] = 1'b1;
    rd(6'd19, d); chk("R10 later rise sets", d, 32'h200);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    do_reset();
    wr(6'd16, 32'hffff_ffff); wr(6'd17, 32'hffff_ffff);
    wr(6'd18, 32'hffff_ffff); wr(6'd19, 32'hffff_ffff);
    wr(6'd23, 32'hffff_ffff); wr(6'd25, 32'hffff_ffff);
    wr(6'd40, 32'hffff_ffff); wr(6'd63, 32'hffff_ffff);
    rd(6'd19, d); chk("R11 raw lo untouched", d, 0);
    rd(6'd18, d); chk("R11 raw hi untouched", d, 0);
    rd(6'd1, d);  chk("R11 mask untouched", d, 32'h1f);
    rd(6'd5, d);  chk("R11 enable untouched", d, 0);
    rd(6'd0, d);  chk("R11 ctrl untouched", d, 0);
    rd(6'd40, d); chk("R11 unmapped reads 0", d, 0);
    chk("R11 no fiq", 32'(fiq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_regs();
    t_num();
    t_nvec();
    t_gate();
    t_fvec();
    t_views();
    t_src();
    t_ignore();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule